// File: doc/BRIEF.md
# Compare Timer with Auto-Reload

This block is a register-mapped alarm timer that watches a free-running 64-bit system count. The count is supplied on an input port, so the block does not count anything itself. Software sets an absolute 64-bit compare point, or sets it relative to the present count through a signed 32-bit timer-value view. The timer condition holds once the count has reached that point.

A second mode re-arms itself. When it is active, the block keeps an auto value equal to the count plus a reload amount. Each time the count reaches the auto value, the block sets a sticky flag and moves the auto value forward by the reload amount from the count at that moment. Software clears the flag by writing zero to it. A single level interrupt follows the timer status unless it is masked.

The register port is a simple synchronous write strobe with a combinational read. Addresses are byte offsets of 32-bit words.

Top module: `cmpt_timer_top`

## Requirements
- R1: After a synchronous active-low reset, every writable register reads zero. The config word at 0x50 reads 1, and irq_o is low.
- R2: These registers read back what was written: the frequency word at 0x10 and the reload word at 0x48. The count reads at 0x00 (low half) and 0x04 (high half). The auto value reads at 0x40 and 0x44. Writes to 0x00, 0x04, 0x40, 0x44 and 0x50 change nothing. Unmapped offsets read zero.
- R3: The control word is at 0x2C. Bit 0 (enable) and bit 1 (mask) are writable. Bit 2 reads the timer status and ignores writes. Bits above bit 2 read zero.
- R4: In compare mode the status is true when the timer is enabled and count >= compare, using an unsigned 64-bit comparison. Writes to 0x20 replace compare bits [31:0] and writes to 0x24 replace bits [63:32]. Each write takes effect on the next cycle.
- R5: A read of 0x28 returns bits [31:0] of (compare - count). A write to 0x28 sets compare to count plus the sign-extended 32-bit write data.
- R6: The auto control word is at 0x4C. Bit 0 is the auto-increment enable. Bit 1 is the sticky flag: writing 0 to it clears it and writing 1 has no effect. If a clear and a reload event fall in the same cycle, the flag stays set.
- R7: Auto mode becomes active when enable and auto enable are both set after not both being set. This can happen either way round. In that cycle the auto value loads count + reload (reload zero-extended).
- R8: While auto mode is active, a cycle with count >= auto value sets the flag and loads the auto value with that cycle's count + reload.
- R9: While auto enable is set, the status equals the enabled timer ANDed with the sticky flag, and compare matches are ignored.
- R10: irq_o is high exactly when the mask is clear and the status is true. A disabled timer reports false status. irq_o follows count_i in the same cycle, without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset for reads and writes |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| count_i | input | 2*DATA_W | System count value |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench goes after the cases that are easy to get subtly wrong.

- **Sign extension on timer-value writes.** A negative value must place the compare point in the past, so the interrupt fires at once. A design that zero-extended would instead schedule it about four billion counts away.
- **Both arming orders, with uneven count steps.** Auto mode is armed enable-first and auto-enable-first while the count advances by steps greater than one. A design that re-armed from the old auto value, or armed on only one of the two transitions, would drift or never fire.
- **Sticky-flag handling.** Writing 1 to the flag must not clear it. A clear that lands on the same cycle as a reload event must not win. A compare value already in the past must stay silent while auto mode is on.
- **Masking and disabling.** These are checked on a live condition, so a registered or latched interrupt would be seen lagging or lingering.

// File: rtl/cmpt_pkg.sv
// Package: shared register offsets and field positions for the compare timer.
// Assumes 32-bit data words addressed by byte offset.
package cmpt_pkg;
    localparam logic [7:0] OFF_CNT_LO  = 8'h00;
    localparam logic [7:0] OFF_CNT_HI  = 8'h04;
    localparam logic [7:0] OFF_FREQ    = 8'h10;
    localparam logic [7:0] OFF_CMP_LO  = 8'h20;
    localparam logic [7:0] OFF_CMP_HI  = 8'h24;
    localparam logic [7:0] OFF_TVAL    = 8'h28;
    localparam logic [7:0] OFF_CTRL    = 8'h2C;
    localparam logic [7:0] OFF_AUTO_LO = 8'h40;
    localparam logic [7:0] OFF_AUTO_HI = 8'h44;
    localparam logic [7:0] OFF_RELOAD  = 8'h48;
    localparam logic [7:0] OFF_ACTRL   = 8'h4C;
    localparam logic [7:0] OFF_CONFIG  = 8'h50;

    localparam int BIT_EN     = 0;
    localparam int BIT_MASK   = 1;
    localparam int BIT_STATUS = 2;
    localparam int BIT_AEN    = 0;
    localparam int BIT_AFLAG  = 1;

    localparam logic [3:0] CFG_AUTO_PRESENT = 4'h1;
endpackage

// File: rtl/cmpt_compare_unit.sv
// Module: holds the absolute compare point and derives the relative view.
// Assumes the count is exactly two data words wide.
module cmpt_compare_unit #(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic              wr_tval_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cval_o,
    output logic [DATA_W-1:0] tval_o,
    output logic              reached_o
);
    logic [CNT_W-1:0] cval_q;
    logic [CNT_W-1:0] wdata_sext;

    // Sign-extend the relative write value to the count width.
    assign wdata_sext = {{DATA_W{wdata_i[DATA_W-1]}}, wdata_i};

    // Update the compare point from absolute or relative writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cval_q <= '0;
        end else if (wr_tval_i) begin
            cval_q <= count_i + wdata_sext;
        end else if (wr_lo_i) begin
            cval_q[DATA_W-1:0] <= wdata_i;
        end else if (wr_hi_i) begin
            cval_q[CNT_W-1:DATA_W] <= wdata_i;
        end
    end

    // Relative view and reach test against the live count.
    always_comb begin
        tval_o    = cval_q[DATA_W-1:0] - count_i[DATA_W-1:0];
        reached_o = (count_i >= cval_q);
        cval_o    = cval_q;
    end

    AST_TVAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tval_i |=> cval_q == $past(count_i) + {{DATA_W{$past(wdata_i[DATA_W-1])}}, $past(wdata_i)}); // R5
endmodule

// File: rtl/cmpt_autoinc_unit.sv
// Module: auto-increment engine with sticky flag and self-rearming point.
// Assumes the timer enable and its next value come from the control register.
module cmpt_autoinc_unit #(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic              tmr_en_i,
    input  logic              tmr_en_nxt_i,
    input  logic              wr_ctl_i,
    input  logic              wr_en_bit_i,
    input  logic              wr_flag_bit_i,
    output logic              aen_o,
    output logic              flag_o,
    output logic [CNT_W-1:0]  aval_o
);
    logic             aen_q, flag_q, aen_nxt, arm, fire;
    logic [CNT_W-1:0] aval_q, next_point;

    // Decode the mode transition and the reload event.
    always_comb begin
        aen_nxt    = wr_ctl_i ? wr_en_bit_i : aen_q;
        arm        = tmr_en_nxt_i && aen_nxt && !(tmr_en_i && aen_q);
        fire       = tmr_en_i && aen_q && (count_i >= aval_q);
        next_point = count_i + {{DATA_W{1'b0}}, reload_i};
    end

    // Auto-enable bit and auto value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aen_q  <= 1'b0;
            aval_q <= '0;
        end else begin
            aen_q <= aen_nxt;
            if (arm || fire) begin
                aval_q <= next_point;
            end
        end
    end

    // Sticky flag: set by a reload event, cleared by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end else if (wr_ctl_i && !wr_flag_bit_i) begin
            flag_q <= 1'b0;
        end
    end

    assign aen_o  = aen_q;
    assign flag_o = flag_q;
    assign aval_o = aval_q;

    AST_FIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en_i && aen_q && count_i >= aval_q) |=>
        (flag_q && aval_q == $past(count_i) + {{DATA_W{1'b0}}, $past(reload_i)})); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_ctl_i && !wr_flag_bit_i)) |=> flag_q); // R6
endmodule

// File: rtl/cmpt_timer_top.sv
// Module: register front end of the compare timer; decodes writes, muxes
// reads and forms the status and level interrupt.
// Assumes one-cycle write strobes and reads that need no strobe.
module cmpt_timer_top #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    import cmpt_pkg::*;

    logic              en_q, mask_q, en_nxt;
    logic [DATA_W-1:0] freq_q, reload_q;
    logic              wr_ctrl, wr_freq, wr_reload, wr_actrl;
    logic              wr_cmp_lo, wr_cmp_hi, wr_tval;
    logic [CNT_W-1:0]  cval, aval;
    logic [DATA_W-1:0] tval;
    logic              reached, aen, aflag, status;

    // Write decode per register.
    always_comb begin
        wr_ctrl   = wr_i && (addr_i == ADDR_W'(OFF_CTRL));
        wr_freq   = wr_i && (addr_i == ADDR_W'(OFF_FREQ));
        wr_reload = wr_i && (addr_i == ADDR_W'(OFF_RELOAD));
        wr_actrl  = wr_i && (addr_i == ADDR_W'(OFF_ACTRL));
        wr_cmp_lo = wr_i && (addr_i == ADDR_W'(OFF_CMP_LO));
        wr_cmp_hi = wr_i && (addr_i == ADDR_W'(OFF_CMP_HI));
        wr_tval   = wr_i && (addr_i == ADDR_W'(OFF_TVAL));
        en_nxt    = wr_ctrl ? wdata_i[BIT_EN] : en_q;
    end

    // Control, frequency and reload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mask_q   <= 1'b0;
            freq_q   <= '0;
            reload_q <= '0;
        end else begin
            en_q <= en_nxt;
            if (wr_ctrl)   mask_q   <= wdata_i[BIT_MASK];
            if (wr_freq)   freq_q   <= wdata_i;
            if (wr_reload) reload_q <= wdata_i;
        end
    end

    cmpt_compare_unit #(.DATA_W(DATA_W)) cmp_u (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_i   (count_i),
        .wr_lo_i   (wr_cmp_lo),
        .wr_hi_i   (wr_cmp_hi),
        .wr_tval_i (wr_tval),
        .wdata_i   (wdata_i),
        .cval_o    (cval),
        .tval_o    (tval),
        .reached_o (reached)
    );

    cmpt_autoinc_unit #(.DATA_W(DATA_W)) ainc_u (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_i       (count_i),
        .reload_i      (reload_q),
        .tmr_en_i      (en_q),
        .tmr_en_nxt_i  (en_nxt),
        .wr_ctl_i      (wr_actrl),
        .wr_en_bit_i   (wdata_i[BIT_AEN]),
        .wr_flag_bit_i (wdata_i[BIT_AFLAG]),
        .aen_o         (aen),
        .flag_o        (aflag),
        .aval_o        (aval)
    );

    // Status selects the sticky flag in auto mode, else the compare.
    always_comb begin
        status = en_q && (aen ? aflag : reached);
        irq_o  = !mask_q && status;
    end

    // Combinational read multiplexer.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFF_CNT_LO):  rdata_o = count_i[DATA_W-1:0];
            ADDR_W'(OFF_CNT_HI):  rdata_o = count_i[CNT_W-1:DATA_W];
            ADDR_W'(OFF_FREQ):    rdata_o = freq_q;
            ADDR_W'(OFF_CMP_LO):  rdata_o = cval[DATA_W-1:0];
            ADDR_W'(OFF_CMP_HI):  rdata_o = cval[CNT_W-1:DATA_W];
            ADDR_W'(OFF_TVAL):    rdata_o = tval;
            ADDR_W'(OFF_CTRL):    rdata_o = {{(DATA_W-3){1'b0}}, status, mask_q, en_q};
            ADDR_W'(OFF_AUTO_LO): rdata_o = aval[DATA_W-1:0];
            ADDR_W'(OFF_AUTO_HI): rdata_o = aval[CNT_W-1:DATA_W];
            ADDR_W'(OFF_RELOAD):  rdata_o = reload_q;
            ADDR_W'(OFF_ACTRL):   rdata_o = {{(DATA_W-2){1'b0}}, aflag, aen};
            ADDR_W'(OFF_CONFIG):  rdata_o = {{(DATA_W-4){1'b0}}, CFG_AUTO_PRESENT};
            default:              rdata_o = '0;
        endcase
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq_o); // R10
    AST_AUTO_HIDES_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && aen && !aflag) |-> !irq_o); // R9
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata_i[BIT_MASK]) |=> !irq_o); // R10
endmodule

// File: tb/cmpt_timer_top_tb_top.sv
`timescale 1ns/100ps
module cmpt_timer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [63:0] cnt = 64'd1000;
    logic [31:0] rdata;
    logic        irq;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          inc = 1;
    bit          done = 1'b0;
    string       ph = "R1";

    // behavioural reference state
    bit          m_en, m_mask, m_aen, m_flag;
    logic [63:0] m_cval, m_aval;
    logic [31:0] m_freq, m_reload;

    always #2 clk = ~clk;

    cmpt_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
        .count_i(cnt), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic bit m_status();
        if (!m_en) return 1'b0;
        if (m_aen) return m_flag;
        return cnt >= m_cval;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return cnt[31:0];
            8'h04: return cnt[63:32];
            8'h10: return m_freq;
            8'h20: return m_cval[31:0];
            8'h24: return m_cval[63:32];
            8'h28: return m_cval[31:0] - cnt[31:0];
            8'h2C: return {29'd0, m_status(), m_mask, m_en};
            8'h40: return m_aval[31:0];
            8'h44: return m_aval[63:32];
            8'h48: return m_reload;
            8'h4C: return {30'd0, m_flag, m_aen};
            8'h50: return 32'd1;
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_reset();
        m_en = 0; m_mask = 0; m_aen = 0; m_flag = 0;
        m_cval = '0; m_aval = '0; m_freq = '0; m_reload = '0;
    endtask

    // Advance the reference by one clock using the inputs present at the edge.
    task automatic m_edge();
        bit n_en, n_aen, fire, arm;
        n_en  = m_en;
        n_aen = m_aen;
        fire  = m_en && m_aen && (cnt >= m_aval);
        if (wr) begin
            case (addr)
                8'h10: m_freq = wdata;
                8'h20: m_cval[31:0] = wdata;
                8'h24: m_cval[63:32] = wdata;
                8'h28: m_cval = cnt + {{32{wdata[31]}}, wdata};
                8'h2C: begin n_en = wdata[0]; m_mask = wdata[1]; end
                8'h48: m_reload = wdata;
                8'h4C: n_aen = wdata[0];
                default: ;
            endcase
        end
        arm = n_en && n_aen && !(m_en && m_aen);
        if (arm || fire) m_aval = cnt + {32'd0, m_reload};
        if (fire) m_flag = 1;
        else if (wr && addr == 8'h4C && !wdata[1]) m_flag = 0;
        m_en = n_en;
        m_aen = n_aen;
    endtask

    task automatic compare();
        logic [31:0] er;
        bit ei;
        er = m_read(addr);
        ei = !m_mask && m_status();
        n_cmp++;
        if (rdata !== er) begin
            n_bad++;
            $display("FAIL %s rdata @%h actual %h expected %h", ph, addr, rdata, er);
        end
        n_cmp++;
        if (irq !== ei) begin
            n_bad++;
            $display("FAIL %s irq actual %b expected %b", ph, irq, ei);
        end
    endtask

    // One clock: check outputs mid-cycle, advance model, move count.
    task automatic step();
        #1;
        if (rst_n) compare();
        @(posedge clk);
        if (rst_n) m_edge(); else m_reset();
        @(negedge clk);
        cnt = cnt + 64'(inc);
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic idle(input int n);
        logic [7:0] rl [12] = '{8'h00, 8'h04, 8'h10, 8'h20, 8'h24, 8'h28,
                                8'h2C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50};
        for (int i = 0; i < n; i++) begin
            addr = rl[i % 12];
            step();
        end
    endtask

    initial begin : watchdog
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_reset();
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        ph = "R1"; idle(24);                      // reset values, config = 1
        ph = "R2";
        wreg(8'h10, 32'h0BEE_F00D); wreg(8'h48, 32'd10);
        wreg(8'h00, 32'hFFFF_FFFF); wreg(8'h04, 32'h1); // read-only: ignored
        wreg(8'h40, 32'h1234);     wreg(8'h44, 32'h1);
        wreg(8'h50, 32'h0);
        addr = 8'h60; step(); idle(12);
        ph = "R4";
        wreg(8'h20, cnt[31:0] + 32'd20); wreg(8'h24, cnt[63:32]);
        ph = "R3"; wreg(8'h2C, 32'hFFFF_FFF9);    // enable, status bit written 0 ignored
        ph = "R4"; addr = 8'h2C; for (int i = 0; i < 24; i++) step();
        ph = "R10"; wreg(8'h2C, 32'h3); addr = 8'h2C; step(); step();
        wreg(8'h2C, 32'h1); step(); wreg(8'h2C, 32'h0); step();
        ph = "R5";
        wreg(8'h2C, 32'h1);
        wreg(8'h28, 32'hFFFF_FFFB); addr = 8'h28; step(); step();
        wreg(8'h28, 32'd30); addr = 8'h2C; for (int i = 0; i < 34; i++) step();
        wreg(8'h24, 32'h8000_0000); idle(6);      // far compare point
        ph = "R7"; inc = 3;
        wreg(8'h4C, 32'h1); idle(4);              // armed: timer already on
        ph = "R8"; addr = 8'h40; for (int i = 0; i < 10; i++) step();
        ph = "R6";
        wreg(8'h4C, 32'h3); addr = 8'h4C; step(); // writing 1 keeps flag
        wreg(8'h4C, 32'h1); addr = 8'h4C; step(); step();
        ph = "R9"; wreg(8'h24, 32'h0); wreg(8'h20, 32'h0); idle(6);
        ph = "R6"; addr = 8'h40; for (int i = 0; i < 12; i++) begin
            wreg(8'h4C, 32'h1);                   // clear racing reload events
        end
        ph = "R7"; inc = 7;
        wreg(8'h2C, 32'h0); wreg(8'h4C, 32'h0); wreg(8'h48, 32'd50);
        wreg(8'h4C, 32'h1); idle(3); wreg(8'h2C, 32'h1); // armed: enable second
        ph = "R8"; idle(30);
        ph = "R10"; wreg(8'h2C, 32'h3); idle(4); wreg(8'h2C, 32'h0); idle(4);
        ph = "R9"; wreg(8'h4C, 32'h0); wreg(8'h2C, 32'h1); idle(4);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule